// File: doc/BRIEF.md
# Scroll latch and VRAM address counter unit

This block keeps the scroll position of the tile-graphics layer in two copies. One copy is a set of latches that the processor writes through three byte ports: a control register, a scroll port and an address port. The other copy is a set of live counters. The counters produce the VRAM address for data-port accesses and for the name table and attribute fetches made during rendering. A single write-order flip-flop decides whether a byte written to the scroll port or to the address port is the first or the second byte of a pair. A status-register read clears this flip-flop.

The position is held in five fields: fine vertical (3 bits), vertical nametable select, horizontal nametable select, coarse vertical (5 bits) and coarse horizontal (5 bits). The fine horizontal scroll (3 bits) lives only in a latch and goes straight to an output. The counters move in three ways:
- Data-port accesses step them as one 15-bit counter, by 1 or by 32.
- Rendering strobes step the horizontal fields every tile and the vertical fields every scanline.
- Reload strobes copy the latches back into the counters.

All rendering strobes act only while rendering is enabled.

Top module: `scroll_addr_unit`

## Requirements
- R1: After reset every latch, counter and the write-order flip-flop are zero. The outputs are then data address 0x0000, name table address 0x2000, attribute address 0x23C0, fine scroll 0 and attribute select 0.
- R2: One write-order flip-flop serves both the scroll port and the address port. Each write to either port flips it. A status read sets it back to the first-write state.
- R3: A first scroll write loads coarse horizontal from data bits 7..3 and fine horizontal from bits 2..0. A second scroll write loads coarse vertical from bits 7..3 and fine vertical from bits 2..0. The fine horizontal latch drives fine_x_o directly.
- R4: A first address write has these effects:
  - data bits 5..4 go to fine vertical bits 1..0, and fine vertical bit 2 is cleared;
  - bit 3 goes to the vertical select and bit 2 to the horizontal select;
  - bits 1..0 go to coarse vertical bits 4..3.
- R5: A second address write loads coarse vertical bits 2..0 from data bits 7..5 and coarse horizontal from bits 4..0. On the same clock edge it copies every latch, including the new values, into the counters.
- R6: A control write loads the horizontal select latch from bit 0 and the vertical select latch from bit 1. Bit 2 picks the data-port step: 0 means step by 1, and 1 means step by 32.
- R7: With a step of 1, each data-port access adds one to the 15-bit chain {fine vertical, vertical select, horizontal select, coarse vertical, coarse horizontal}, with coarse horizontal at the low end. The chain wraps modulo 2^15. data_addr_o is the low 14 bits of the chain.
- R8: With a step of 32, each data-port access adds 32 to the same chain, so coarse vertical is the lowest field that changes.
- R9: A rendering tile strobe increments {horizontal select, coarse horizontal} as a 6-bit counter that wraps from 63 to 0.
- R10: A rendering line strobe increments fine vertical. When fine vertical goes from 7 to 0, coarse vertical steps:
  - from 29 it goes to 0 and the vertical select toggles;
  - from 31 it wraps to 0 and the vertical select is left unchanged.
  
  The horizontal fields are not touched.
- R11: A frame reload strobe copies all latches into the counters. A line reload strobe copies only the horizontal select and coarse horizontal. When rendering is disabled, the tile, line, line-reload and frame-reload strobes have no effect.
- R12: The name table address is {2'b10, vertical select, horizontal select, coarse vertical, coarse horizontal}. The attribute address is {2'b10, vertical select, horizontal select, 4'b1111, coarse vertical[4:2], coarse horizontal[4:2]}. attr_sel_o is {coarse vertical[1], coarse horizontal[1]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_ctrl_i | input | 1 | Write strobe for the control register |
| wr_scroll_i | input | 1 | Write strobe for the scroll port |
| wr_addr_i | input | 1 | Write strobe for the address port |
| wdata_i | input | 8 | Write data byte |
| status_rd_i | input | 1 | Status-register read strobe |
| data_acc_i | input | 1 | Data-port access strobe (read or write) |
| render_en_i | input | 1 | Rendering enabled, level |
| tile_tick_i | input | 1 | Horizontal tile increment strobe |
| line_tick_i | input | 1 | Vertical scanline increment strobe |
| hreload_i | input | 1 | Horizontal reload strobe at end of horizontal blanking |
| vreload_i | input | 1 | Full reload strobe at start of pre-render line |
| data_addr_o | output | 14 | VRAM address for data-port accesses |
| nt_addr_o | output | 14 | Name table fetch address |
| at_addr_o | output | 14 | Attribute fetch address |
| fine_x_o | output | 3 | Fine horizontal scroll |
| attr_sel_o | output | 2 | Selects the 2-bit slice of the attribute byte |

## Verification
The assertions take for granted that at most one of the nine strobes (three writes, status read, data access and the four rendering strobes) is high in any clock cycle. The step and reload relations they check are stated for one event at a time. The stimulus issues exactly one strobe or none per cycle, both in the directed phases and in the random phase. It toggles render enable only as a level between events.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  localparam int unsigned CRS_W   = 5;
  localparam int unsigned FINE_W  = 3;
  localparam int unsigned ADDR_W  = 14;
  localparam int unsigned CHAIN_W = FINE_W + 2 + 2 * CRS_W;
  localparam int unsigned HPOS_W  = CRS_W + 1;
  localparam logic [CRS_W-1:0] VT_LAST = CRS_W'(29);
  localparam logic [1:0] NT_BASE = 2'b10;
  localparam logic [3:0] AT_ROW  = 4'hF;

  // field order is the data-port carry chain, msb first
  typedef struct packed {
    logic [FINE_W-1:0] fv;
    logic              v;
    logic              h;
    logic [CRS_W-1:0]  vt;
    logic [CRS_W-1:0]  ht;
  } vpos_t;
endpackage

// File: rtl/scroll_latch.sv
module scroll_latch
  import scroll_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_scroll_i,
  input  logic              wr_addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              status_rd_i,
  output vpos_t             lat_q_o,
  output vpos_t             lat_d_o,
  output logic [FINE_W-1:0] fine_x_o,
  output logic              inc32_o,
  output logic              toggle_o,
  output logic              copy_o
);
  vpos_t             lat_q, lat_d;
  logic [FINE_W-1:0] fh_q, fh_d;
  logic              inc_q, inc_d, tog_q, tog_d;

  always_comb begin
    lat_d  = lat_q;
    fh_d   = fh_q;
    inc_d  = inc_q;
    tog_d  = tog_q;
    copy_o = 1'b0;
    if (wr_ctrl_i) begin
      lat_d.h = wdata_i[0];
      lat_d.v = wdata_i[1];
      inc_d   = wdata_i[2];
    end else if (wr_scroll_i) begin
      tog_d = ~tog_q;
      if (!tog_q) begin
        lat_d.ht = wdata_i[7:3];
        fh_d     = wdata_i[2:0];
      end else begin
        lat_d.vt = wdata_i[7:3];
        lat_d.fv = wdata_i[2:0];
      end
    end else if (wr_addr_i) begin
      tog_d = ~tog_q;
      if (!tog_q) begin
        lat_d.fv        = {1'b0, wdata_i[5:4]};
        lat_d.v         = wdata_i[3];
        lat_d.h         = wdata_i[2];
        lat_d.vt[4:3]   = wdata_i[1:0];
      end else begin
        lat_d.vt[2:0]   = wdata_i[7:5];
        lat_d.ht        = wdata_i[4:0];
        copy_o          = 1'b1;
      end
    end else if (status_rd_i) begin
      tog_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      fh_q  <= '0;
      inc_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
      fh_q  <= fh_d;
      inc_q <= inc_d;
      tog_q <= tog_d;
    end
  end

  assign lat_q_o  = lat_q;
  assign lat_d_o  = lat_d;
  assign fine_x_o = fh_q;
  assign inc32_o  = inc_q;
  assign toggle_o = tog_q;
endmodule

// File: rtl/scroll_counter.sv
module scroll_counter
  import scroll_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  vpos_t lat_q_i,
  input  vpos_t lat_d_i,
  input  logic  copy_i,
  input  logic  render_en_i,
  input  logic  vreload_i,
  input  logic  hreload_i,
  input  logic  data_acc_i,
  input  logic  inc32_i,
  input  logic  line_tick_i,
  input  logic  tile_tick_i,
  output vpos_t cnt_o
);
  vpos_t              cnt_q, cnt_d, vnext;
  logic [HPOS_W-1:0]  hnext;
  logic [CHAIN_W-1:0] step, chain_sum;

  assign step      = inc32_i ? CHAIN_W'(1 << CRS_W) : CHAIN_W'(1);
  assign chain_sum = cnt_q + step;
  assign hnext     = {cnt_q.h, cnt_q.ht} + HPOS_W'(1);

  always_comb begin
    vnext    = cnt_q;
    vnext.fv = cnt_q.fv + FINE_W'(1);
    if (cnt_q.fv == '1) begin
      if (cnt_q.vt == VT_LAST) begin
        vnext.vt = '0;
        vnext.v  = ~cnt_q.v;
      end else begin
        vnext.vt = cnt_q.vt + CRS_W'(1);
      end
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (copy_i) begin
      cnt_d = lat_d_i;
    end else if (render_en_i && vreload_i) begin
      cnt_d = lat_q_i;
    end else if (render_en_i && hreload_i) begin
      cnt_d.h  = lat_q_i.h;
      cnt_d.ht = lat_q_i.ht;
    end else if (data_acc_i) begin
      cnt_d = vpos_t'(chain_sum);
    end else if (render_en_i && line_tick_i) begin
      cnt_d = vnext;
    end else if (render_en_i && tile_tick_i) begin
      {cnt_d.h, cnt_d.ht} = hnext;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/scroll_addr_mux.sv
module scroll_addr_mux
  import scroll_pkg::*;
(
  input  vpos_t             cnt_i,
  output logic [ADDR_W-1:0] data_addr_o,
  output logic [ADDR_W-1:0] nt_addr_o,
  output logic [ADDR_W-1:0] at_addr_o,
  output logic [1:0]        attr_sel_o
);
  assign data_addr_o = cnt_i[ADDR_W-1:0];
  assign nt_addr_o   = {NT_BASE, cnt_i.v, cnt_i.h, cnt_i.vt, cnt_i.ht};
  assign at_addr_o   = {NT_BASE, cnt_i.v, cnt_i.h, AT_ROW,
                        cnt_i.vt[CRS_W-1:CRS_W-3], cnt_i.ht[CRS_W-1:CRS_W-3]};
  assign attr_sel_o  = {cnt_i.vt[1], cnt_i.ht[1]};
endmodule

// File: rtl/scroll_addr_unit.sv
module scroll_addr_unit
  import scroll_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_ctrl_i,
  input  logic        wr_scroll_i,
  input  logic        wr_addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        status_rd_i,
  input  logic        data_acc_i,
  input  logic        render_en_i,
  input  logic        tile_tick_i,
  input  logic        line_tick_i,
  input  logic        hreload_i,
  input  logic        vreload_i,
  output logic [13:0] data_addr_o,
  output logic [13:0] nt_addr_o,
  output logic [13:0] at_addr_o,
  output logic [2:0]  fine_x_o,
  output logic [1:0]  attr_sel_o
);
  vpos_t lat_q, lat_d, cnt;
  logic  inc32, toggle, copy;

  scroll_latch u_latch (
    .clk_i, .rst_ni, .wr_ctrl_i, .wr_scroll_i, .wr_addr_i, .wdata_i, .status_rd_i,
    .lat_q_o(lat_q), .lat_d_o(lat_d), .fine_x_o, .inc32_o(inc32),
    .toggle_o(toggle), .copy_o(copy)
  );

  scroll_counter u_cnt (
    .clk_i, .rst_ni, .lat_q_i(lat_q), .lat_d_i(lat_d), .copy_i(copy),
    .render_en_i, .vreload_i, .hreload_i, .data_acc_i, .inc32_i(inc32),
    .line_tick_i, .tile_tick_i, .cnt_o(cnt)
  );

  scroll_addr_mux u_mux (
    .cnt_i(cnt), .data_addr_o, .nt_addr_o, .at_addr_o, .attr_sel_o
  );
endmodule

// File: rtl/scroll_addr_unit_chk.sv
module scroll_addr_unit_chk
  import scroll_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_ctrl_i,
  input logic        wr_scroll_i,
  input logic        wr_addr_i,
  input logic [7:0]  wdata_i,
  input logic        status_rd_i,
  input logic        data_acc_i,
  input logic        render_en_i,
  input logic        tile_tick_i,
  input logic        line_tick_i,
  input logic        hreload_i,
  input logic        vreload_i,
  input logic [13:0] data_addr_o,
  input logic [13:0] nt_addr_o,
  input logic        toggle_i,
  input logic        inc32_i,
  input vpos_t       lat_i
);
  // input contract: one strobe per cycle
  assert_one_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_ctrl_i, wr_scroll_i, wr_addr_i, status_rd_i, data_acc_i,
              tile_tick_i, line_tick_i, hreload_i, vreload_i}));

  assert_toggle_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i |=> !toggle_i);

  assert_copy_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr_i && toggle_i |=> data_addr_o[7:0] == $past(wdata_i));

  assert_step_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc_i && !inc32_i |=> data_addr_o == $past(data_addr_o) + 14'd1);

  assert_step_row_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc_i && inc32_i |=> data_addr_o == $past(data_addr_o) + 14'd32);

  assert_tile_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    render_en_i && tile_tick_i |=>
      {nt_addr_o[10], nt_addr_o[4:0]} == $past({nt_addr_o[10], nt_addr_o[4:0]}) + 6'd1);

  assert_line_keeps_x_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    render_en_i && line_tick_i |=> nt_addr_o[4:0] == $past(nt_addr_o[4:0]));

  assert_hreload_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    render_en_i && hreload_i |=>
      {nt_addr_o[10], nt_addr_o[4:0]} == $past({lat_i.h, lat_i.ht}) &&
      nt_addr_o[9:5] == $past(nt_addr_o[9:5]));

  assert_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !render_en_i && (tile_tick_i || line_tick_i || hreload_i || vreload_i) |=>
      $stable(data_addr_o) && $stable(nt_addr_o));
endmodule

bind scroll_addr_unit scroll_addr_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_ctrl_i(wr_ctrl_i), .wr_scroll_i(wr_scroll_i),
  .wr_addr_i(wr_addr_i), .wdata_i(wdata_i), .status_rd_i(status_rd_i),
  .data_acc_i(data_acc_i), .render_en_i(render_en_i), .tile_tick_i(tile_tick_i),
  .line_tick_i(line_tick_i), .hreload_i(hreload_i), .vreload_i(vreload_i),
  .data_addr_o(data_addr_o), .nt_addr_o(nt_addr_o), .toggle_i(toggle),
  .inc32_i(inc32), .lat_i(lat_q)
);

// File: tb/scroll_addr_unit_tb_top.sv
module scroll_addr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 0, rst_ni = 0;
  logic wr_ctrl_i = 0, wr_scroll_i = 0, wr_addr_i = 0, status_rd_i = 0, data_acc_i = 0;
  logic render_en_i = 0, tile_tick_i = 0, line_tick_i = 0, hreload_i = 0, vreload_i = 0;
  logic [7:0]  wdata_i = 0;
  logic [13:0] data_addr_o, nt_addr_o, at_addr_o;
  logic [2:0]  fine_x_o;
  logic [1:0]  attr_sel_o;

  int checks = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  scroll_addr_unit dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model state
  int l_fv, l_v, l_h, l_vt, l_ht, l_fh, m_inc, m_tog;
  int c_fv, c_v, c_h, c_vt, c_ht;

  always @(posedge clk_i or negedge rst_ni) begin
    int n_fv, n_v, n_h, n_vt, n_ht, n_fh, n_inc, n_tog, cp, ch;
    if (!rst_ni) begin
      l_fv = 0; l_v = 0; l_h = 0; l_vt = 0; l_ht = 0; l_fh = 0; m_inc = 0; m_tog = 0;
      c_fv = 0; c_v = 0; c_h = 0; c_vt = 0; c_ht = 0;
    end else begin
      n_fv = l_fv; n_v = l_v; n_h = l_h; n_vt = l_vt; n_ht = l_ht; n_fh = l_fh;
      n_inc = m_inc; n_tog = m_tog; cp = 0;
      if (wr_ctrl_i) begin
        n_h = wdata_i[0]; n_v = wdata_i[1]; n_inc = wdata_i[2];
      end else if (wr_scroll_i) begin
        if (m_tog == 0) begin n_ht = wdata_i / 8; n_fh = wdata_i % 8; end
        else begin n_vt = wdata_i / 8; n_fv = wdata_i % 8; end
        n_tog = 1 - m_tog;
      end else if (wr_addr_i) begin
        if (m_tog == 0) begin
          n_fv = (wdata_i / 16) % 4; n_v = (wdata_i / 8) % 2; n_h = (wdata_i / 4) % 2;
          n_vt = (l_vt % 8) + (wdata_i % 4) * 8;
        end else begin
          n_vt = (l_vt / 8) * 8 + wdata_i / 32; n_ht = wdata_i % 32; cp = 1;
        end
        n_tog = 1 - m_tog;
      end else if (status_rd_i) n_tog = 0;

      if (cp == 1) begin
        c_fv = n_fv; c_v = n_v; c_h = n_h; c_vt = n_vt; c_ht = n_ht;
      end else if (render_en_i && vreload_i) begin
        c_fv = l_fv; c_v = l_v; c_h = l_h; c_vt = l_vt; c_ht = l_ht;
      end else if (render_en_i && hreload_i) begin
        c_h = l_h; c_ht = l_ht;
      end else if (data_acc_i) begin
        ch = c_fv * 4096 + c_v * 2048 + c_h * 1024 + c_vt * 32 + c_ht;
        ch = (ch + ((m_inc != 0) ? 32 : 1)) % 32768;
        c_fv = ch / 4096; c_v = (ch / 2048) % 2; c_h = (ch / 1024) % 2;
        c_vt = (ch / 32) % 32; c_ht = ch % 32;
      end else if (render_en_i && line_tick_i) begin
        if (c_fv < 7) c_fv = c_fv + 1;
        else begin
          c_fv = 0;
          if (c_vt == 29) begin c_vt = 0; c_v = 1 - c_v; end
          else c_vt = (c_vt + 1) % 32;
        end
      end else if (render_en_i && tile_tick_i) begin
        ch = (c_h * 32 + c_ht + 1) % 64;
        c_h = ch / 32; c_ht = ch % 32;
      end
      l_fv = n_fv; l_v = n_v; l_h = n_h; l_vt = n_vt; l_ht = n_ht; l_fh = n_fh;
      m_inc = n_inc; m_tog = n_tog;
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int base;
    base = c_v * 2048 + c_h * 1024;
    cmp("data_addr", data_addr_o, (c_fv % 4) * 4096 + base + c_vt * 32 + c_ht);
    cmp("nt_addr", nt_addr_o, 8192 + base + c_vt * 32 + c_ht);
    cmp("at_addr", at_addr_o, 8192 + base + 960 + (c_vt / 4) * 8 + c_ht / 4);
    cmp("fine_x", fine_x_o, l_fh);
    cmp("attr_sel", attr_sel_o, ((c_vt / 2) % 2) * 2 + (c_ht / 2) % 2);
  endtask

  task automatic cyc();
    @(negedge clk_i);
    compare_all();
    wr_ctrl_i = 0; wr_scroll_i = 0; wr_addr_i = 0; status_rd_i = 0; data_acc_i = 0;
    tile_tick_i = 0; line_tick_i = 0; hreload_i = 0; vreload_i = 0;
  endtask

  task automatic ctrl(input logic [7:0] d);  wr_ctrl_i = 1;   wdata_i = d; cyc(); endtask
  task automatic scrl(input logic [7:0] d);  wr_scroll_i = 1; wdata_i = d; cyc(); endtask
  task automatic addr(input logic [7:0] d);  wr_addr_i = 1;   wdata_i = d; cyc(); endtask
  task automatic stat();  status_rd_i = 1; cyc(); endtask
  task automatic acc();   data_acc_i = 1;  cyc(); endtask
  task automatic tile();  tile_tick_i = 1; cyc(); endtask
  task automatic line();  line_tick_i = 1; cyc(); endtask
  task automatic hrel();  hreload_i = 1;   cyc(); endtask
  task automatic vrel();  vreload_i = 1;   cyc(); endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    cur_req = "R1"; compare_all();   // reset state
    @(negedge clk_i); compare_all();
    rst_ni = 1;
    cyc();

    cur_req = "R6"; ctrl(8'h03); render_en_i = 1; vrel();
    cur_req = "R3"; scrl(8'h7D); scrl(8'h5E); hrel(); vrel();
    cur_req = "R2"; scrl(8'hA2); stat(); scrl(8'h13); vrel(); addr(8'h21); stat(); addr(8'h05); addr(8'hE7);
    cur_req = "R4"; render_en_i = 0; addr(8'h3F); cyc(); addr(8'h10);
    cur_req = "R5"; addr(8'h2A); addr(8'hC3); addr(8'h3F); addr(8'hFF);
    cur_req = "R7"; ctrl(8'h00); for (int i = 0; i < 40; i++) acc();
    addr(8'h00); addr(8'h1E); for (int i = 0; i < 40; i++) acc();
    cur_req = "R8"; ctrl(8'h04); for (int i = 0; i < 80; i++) acc();
    cur_req = "R9"; render_en_i = 1; for (int i = 0; i < 70; i++) tile();
    cur_req = "R10"; ctrl(8'h00); stat(); addr(8'h3B); addr(8'hA4);
    for (int i = 0; i < 300; i++) line();
    scrl(8'h00); scrl(8'hF8); vrel(); for (int i = 0; i < 20; i++) line();
    cur_req = "R11"; scrl(8'h4B); scrl(8'h91); for (int i = 0; i < 5; i++) tile();
    hrel(); for (int i = 0; i < 9; i++) line(); vrel();
    render_en_i = 0; tile(); line(); hrel(); vrel(); render_en_i = 1; hrel();
    cur_req = "R12"; for (int i = 0; i < 64; i++) tile();

    cur_req = "R12";
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 11);
      wdata_i = 8'($urandom);
      if (sel == 10) render_en_i = ~render_en_i;
      case (sel)
        0: wr_ctrl_i = 1;   1: wr_scroll_i = 1; 2: wr_addr_i = 1;
        3: status_rd_i = 1; 4: data_acc_i = 1;  5: tile_tick_i = 1;
        6: line_tick_i = 1; 7: hreload_i = 1;   8: vreload_i = 1;
        default: ;
      endcase
      cyc();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule